// File: doc/BRIEF.md
# Quarter-Rate Digital I/Q Downconverter

This block turns one stream of real, signed samples from a single fast converter into a pair of in-phase (I) and quadrature (Q) streams. It mixes each sample with a local oscillator running at exactly one quarter of the sample rate. At that frequency the cosine and sine references only ever take the values +1, 0 and -1, so each product is a choice between the sample, its two's-complement negation, or zero. No multiplier and no oscillator table is needed. For example, a 120 Msps stream is shifted down by 30 MHz.

The oscillator phase is a four-state machine that steps once per accepted sample. The states are `PH_0` (cos +1, sin 0), `PH_90` (cos 0, sin +1), `PH_180` (cos -1, sin 0) and `PH_270` (cos 0, sin -1). There are two kinds of transition:
- **advance**: on a valid sample the machine moves PH_0 → PH_90 → PH_180 → PH_270 → PH_0.
- **hold**: with no valid sample it stays in its state.

A synchronous reset forces `PH_0`. When the wanted band sits above half the sample rate, undersampling folds it back mirror-imaged and its sidebands swap. The `flip_q` control negates the Q product to undo this. It is taken together with each valid sample.

Top module: `iq_quarter_ddc`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `iq_valid` is 0 and `i_data` and `q_data` are 0. The oscillator phase restarts at PH_0, so the first valid sample after reset is multiplied by cos = +1 and sin = 0.
- R2: On successive valid samples, I equals the sample times the cosine sequence +1, 0, -1, 0, repeating.
- R3: On successive valid samples, Q equals the sample times the sine sequence 0, +1, 0, -1, repeating, in lock with the cosine sequence. When the reference is 0, the output is exactly 0.
- R4: The phase advances only on cycles with `smp_valid` = 1. Idle cycles between samples do not shift the sequence.
- R5: Latency is one cycle. `iq_valid` in cycle n+1 equals `smp_valid` in cycle n, and the data it marks belongs to the sample of cycle n.
- R6: The outputs are one bit wider than the input. Negating the most negative input -2^(W-1) gives +2^(W-1) exactly, with no wrap.
- R7: When `flip_q` = 1 together with a valid sample, that sample's Q output is negated. Its I output is unchanged.
- R8: On cycles without a valid sample, `i_data` and `q_data` keep their previous values. A change of `flip_q` on such a cycle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | W | Signed input sample (W = 12 by default) |
| flip_q | input | 1 | Negate Q for this sample (sideband correction) |
| iq_valid | output | 1 | Output sample strobe, one cycle after `smp_valid` |
| i_data | output | W+1 | Signed in-phase product |
| q_data | output | W+1 | Signed quadrature product |

## Verification
The bench drives gapped valid patterns, so a phase machine that steps on idle cycles puts the ±1 references on the wrong samples. It feeds the most negative code in all four phases, where a design without the extra output bit wraps to a negative result. It toggles `flip_q` both with valid samples and between them. A design that applies the inversion to I or latches it on idle cycles then shows wrong signs. It also asserts reset in mid-stream, where a phase that fails to return to PH_0 starts the next burst misaligned.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    // Oscillator phase, one state per quarter cycle of the fs/4 tone.
    typedef enum logic [1:0] {
        PH_0   = 2'd0,
        PH_90  = 2'd1,
        PH_180 = 2'd2,
        PH_270 = 2'd3
    } lo_phase_t;

    // Product selection replacing a multiply by +1, 0 or -1.
    typedef enum logic [1:0] {
        MIX_ZERO = 2'd0,
        MIX_PASS = 2'd1,
        MIX_NEG  = 2'd2
    } mix_op_t;

    localparam int unsigned LANES = 2;
    localparam int unsigned LANE_I = 0;
    localparam int unsigned LANE_Q = 1;

    function automatic mix_op_t mix_op_negate(input mix_op_t op);
        unique case (op)
            MIX_PASS: return MIX_NEG;
            MIX_NEG:  return MIX_PASS;
            default:  return MIX_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/ddc_lo_phase.sv
module ddc_lo_phase
    import ddc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    adv,
    output mix_op_t cos_op,
    output mix_op_t sin_op
);

    lo_phase_t state_q;
    lo_phase_t state_d;

    // Next-state: advance on a valid sample, hold otherwise.
    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                PH_0:    state_d = PH_90;
                PH_90:   state_d = PH_180;
                PH_180:  state_d = PH_270;
                PH_270:  state_d = PH_0;
                default: state_d = PH_0;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_0;
        else     state_q <= state_d;
    end

    // Outputs: reference values of the current phase.
    always_comb begin
        unique case (state_q)
            PH_0:    begin cos_op = MIX_PASS; sin_op = MIX_ZERO; end
            PH_90:   begin cos_op = MIX_ZERO; sin_op = MIX_PASS; end
            PH_180:  begin cos_op = MIX_NEG;  sin_op = MIX_ZERO; end
            PH_270:  begin cos_op = MIX_ZERO; sin_op = MIX_NEG;  end
            default: begin cos_op = MIX_ZERO; sin_op = MIX_ZERO; end
        endcase
    end

    // R4: no valid sample, no phase movement
    a_r4_hold_phase: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state_q));

    // R2: each valid sample moves exactly one quarter cycle
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        adv |=> (state_q == lo_phase_t'($past(state_q) + 2'd1)));

    // R3: exactly one reference is nonzero in every phase
    a_r3_one_active: assert property (@(posedge clk) disable iff (rst)
        (cos_op == MIX_ZERO) != (sin_op == MIX_ZERO));

endmodule

// File: rtl/ddc_mix_lane.sv
module ddc_mix_lane
    import ddc_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  mix_op_t      op,
    input  logic [W-1:0] din,
    output logic [W:0]   dout
);

    localparam int unsigned OW = W + 1;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [OW-1:0] MOST_NEG_FLIPPED = {2'b01, {(W-1){1'b0}}};

    logic [OW-1:0] ext;
    logic [OW-1:0] prod;

    assign ext = {din[W-1], din};

    always_comb begin
        unique case (op)
            MIX_PASS: prod = ext;
            MIX_NEG:  prod = ~ext + {{(OW-1){1'b0}}, 1'b1};
            default:  prod = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (en) dout <= prod;
    end

    // R8: output held between valid samples
    a_r8_hold_data: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(dout));

    // R3: zero reference gives exactly zero
    a_r3_zero_product: assert property (@(posedge clk) disable iff (rst)
        (en && op == MIX_ZERO) |=> (dout == '0));

    // R6: negating the most negative code does not wrap
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (en && op == MIX_NEG && din == MOST_NEG) |=> (dout == MOST_NEG_FLIPPED));

endmodule

// File: rtl/iq_quarter_ddc.sv
module iq_quarter_ddc
    import ddc_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    input  logic         flip_q,
    output logic         iq_valid,
    output logic [W:0]   i_data,
    output logic [W:0]   q_data
);

    mix_op_t cos_op;
    mix_op_t sin_op;
    mix_op_t lane_op [LANES];
    logic [W:0] lane_out [LANES];

    ddc_lo_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .adv    (smp_valid),
        .cos_op (cos_op),
        .sin_op (sin_op)
    );

    // Sideband correction folded into the Q selection.
    assign lane_op[LANE_I] = cos_op;
    assign lane_op[LANE_Q] = flip_q ? mix_op_negate(sin_op) : sin_op;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ddc_mix_lane #(.W(W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .en   (smp_valid),
            .op   (lane_op[g]),
            .din  (smp_data),
            .dout (lane_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) iq_valid <= 1'b0;
        else     iq_valid <= smp_valid;
    end

    assign i_data = lane_out[LANE_I];
    assign q_data = lane_out[LANE_Q];

    // R5: strobe follows input strobe after one cycle
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> iq_valid);
    a_r5_idle_latency: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !iq_valid);

    // R7: Q flips sign against the unflipped reference when requested
    a_r7_flip_sign: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && flip_q && sin_op == MIX_PASS && !smp_data[W-1] && smp_data != '0)
            |=> q_data[W]);

endmodule

// File: tb/iq_quarter_ddc_tb.sv
module iq_quarter_ddc_tb;

    localparam int W = 12;
    localparam int MOST_NEG = -(1 << (W - 1));

    logic clk = 1'b0;
    logic rst;
    logic smp_valid;
    logic [W-1:0] smp_data;
    logic flip_q;
    logic iq_valid;
    logic [W:0] i_data;
    logic [W:0] q_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // Reference model state
    int ref_phase = 0;
    int exp_v = 0;
    int exp_i = 0;
    int exp_q = 0;

    always #2 clk = ~clk;

    iq_quarter_ddc #(.W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .flip_q    (flip_q),
        .iq_valid  (iq_valid),
        .i_data    (i_data),
        .q_data    (q_data)
    );

    task automatic check(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        check("iq_valid", int'(iq_valid), exp_v);
        check("i_data", int'($signed(i_data)), exp_i);
        check("q_data", int'($signed(q_data)), exp_q);
    endtask

    // One cycle: check outputs, update the model with what will be latched, apply.
    task automatic step(input bit v, input int x, input bit inv, input bit r = 0);
        @(negedge clk);
        compare_all();
        if (r) begin
            ref_phase = 0; exp_v = 0; exp_i = 0; exp_q = 0;
        end else begin
            exp_v = v;
            if (v) begin
                int c;
                int s;
                c = (ref_phase == 0) ? 1 : (ref_phase == 2) ? -1 : 0;
                s = (ref_phase == 1) ? 1 : (ref_phase == 3) ? -1 : 0;
                exp_i = x * c;
                exp_q = x * s * (inv ? -1 : 1);
                ref_phase = (ref_phase + 1) % 4;
            end
        end
        rst = r;
        smp_valid = v;
        smp_data = x[W-1:0];
        flip_q = inv;
    endtask

    initial begin
        rst = 1'b1; smp_valid = 1'b1; smp_data = 12'h5A5; flip_q = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        tag = "R1";
        check("iq_valid in reset", int'(iq_valid), 0);
        check("i_data in reset", int'($signed(i_data)), 0);
        check("q_data in reset", int'($signed(q_data)), 0);
        rst = 1'b0; smp_valid = 1'b0; flip_q = 1'b0;
        step(1, 100, 0);              // R1: first sample uses PH_0
        // R2/R3/R5: continuous ramp
        tag = "R2";
        for (int k = 0; k < 12; k++) step(1, 37 * k - 150, 0);
        tag = "R3";
        for (int k = 0; k < 8; k++) step(1, 500 - 90 * k, 0);
        // R4/R5: gapped strobes
        tag = "R4";
        for (int k = 0; k < 20; k++) step((k % 3) == 0, 11 * k + 3, 0);
        tag = "R5";
        step(1, 7, 0); step(0, 0, 0); step(1, -9, 0); step(1, 13, 0); step(0, 0, 0);
        // R6: most negative input in all four phases, both flip settings
        tag = "R6";
        for (int k = 0; k < 8; k++) step(1, MOST_NEG, k >= 4);
        step(1, (1 << (W - 1)) - 1, 0);
        // R7: flip with valid samples
        tag = "R7";
        for (int k = 0; k < 8; k++) step(1, 300 + k, k[0]);
        // R8: flip toggled on idle cycles only
        tag = "R8";
        for (int k = 0; k < 10; k++) step(k == 0 || k == 9, 222, (k % 2) == 1);
        // R1: mid-stream reset restarts at PH_0
        tag = "R1";
        step(1, 55, 0); step(1, 66, 0);
        step(1, 77, 1, 1); step(0, 0, 0, 1);
        for (int k = 0; k < 4; k++) step(1, 123, 0);
        // Mixed random traffic
        tag = "R2";
        for (int k = 0; k < 400; k++)
            step(($urandom % 4) != 0, int'($urandom % (1 << W)) + MOST_NEG, ($urandom % 2) == 1);
        step(0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule